// File: doc/BRIEF.md
# Bus-Master Memory Cycle Sequencer

This block runs the memory cycles that a DMA engine issues while its device owns the system bus. A requester hands it one transfer (address, direction, write data). The block then walks the bus through a first clock (T1), a strobe phase (T2) and as many wait clocks as the slave needs. It finishes the transfer when the selected termination rule is met, and returns read data together with a one-clock completion pulse.

Termination follows one of two static disciplines. In acknowledge mode, two active-low acknowledge inputs end the cycle, and the configured data width decides whether both are needed or only one. The bus width is never derived from the acknowledge pattern. In ready mode, a single ready input holds the cycle while high and ends it when low. The termination and retry inputs are either used directly at the clock edge or first passed through a synchronizer, as a configuration bit selects.

A bus-retry input aborts the running cycle and replays it unchanged once retry is released. In latched-retry configuration, the abort also raises a status flag. The replay still completes, but no new request is accepted until software clears the flag.

Top module: `busm_cycle_ctrl`

## Requirements
- R1: `ecs_n` goes low at the rising edge that begins T1 and returns high at the falling edge inside that same T1 clock. It is high at every other time.
- R2: `ds_n` is high during T1. It goes low at the edge that starts T2 and stays low until the edge that completes or aborts the cycle.
- R3: With `cfg_rdy_mode`=0 and `cfg_wide`=1, a cycle completes only at a sample where `ack0_n` and `ack1_n` are both 0. `ack0_n`=0 alone inserts wait states.
- R4: With `cfg_rdy_mode`=0 and `cfg_wide`=0, `ack1_n`=0 alone completes the cycle. `ack0_n`=0 alone does not.
- R5: With `cfg_rdy_mode`=1, `rdy_in`=1 inserts wait states and `rdy_in`=0 completes the cycle. The acknowledge inputs have no effect.
- R6: A one-clock `req_valid` is accepted while idle with `retry_flag`=0. `busy` is high from the next edge until completion. `done` pulses for one clock at the edge that samples termination. On a read, `rd_data` takes `bus_rdata` at that edge.
- R7: `retry_n`=0 sampled in T2 aborts the cycle: no `done`, and `ds_n` goes high. After `retry_n` is sampled 1, a new T1 starts with the same `bus_addr`, `bus_write` and `bus_wdata`. These outputs stay stable for the whole transfer.
- R8: If retry and a termination are sampled at the same edge, retry wins and the cycle does not complete.
- R9: An abort sets `retry_flag` when `cfg_retry_latch`=1 and leaves it 0 when `cfg_retry_latch`=0. A set flag lets the replay finish but blocks new requests until `retry_clr`=1 clears it. A set and a clear at the same edge leave the flag set.
- R10: With `cfg_async`=1, a change on the termination or retry inputs acts at the third rising edge after it (two synchronizer stages).
- R11: With `cfg_async`=0, a change on those inputs acts at the first rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rdy_mode | input | 1 | 1: ready-input termination, 0: acknowledge pair |
| cfg_wide | input | 1 | 1: 32-bit width (both acks), 0: 16-bit (ack1 only) |
| cfg_async | input | 1 | 1: synchronize termination and retry inputs |
| cfg_retry_latch | input | 1 | 1: retry sets the blocking status flag |
| req_valid | input | 1 | One-clock request to start a transfer |
| req_write | input | 1 | Transfer direction, 1 = write |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Data captured on a completed read |
| bus_addr | output | AW | Address driven on the bus |
| bus_wdata | output | DW | Write data driven on the bus |
| bus_write | output | 1 | Direction driven on the bus |
| ecs_n | output | 1 | Early cycle start, active low |
| ds_n | output | 1 | Data strobe, active low |
| bus_rdata | input | DW | Read data from the slave |
| ack0_n | input | 1 | Slave acknowledge 0, active low |
| ack1_n | input | 1 | Slave acknowledge 1, active low |
| rdy_in | input | 1 | Ready input, 1 = wait, 0 = end |
| retry_n | input | 1 | Bus retry, active low |
| retry_flag | output | 1 | Latched-retry status |
| retry_clr | input | 1 | Software clear for `retry_flag` |

## Verification
Retry and termination can be sampled at the same edge. The bench provokes this by pulling `retry_n` and both acknowledges low together during T2 and holding them for several clocks. It judges the outcome by checking that `done` stays low, `busy` stays high and `bus_addr` is unchanged until retry is released and the replay completes. The same collision is repeated in latched mode, where the bench also checks that the flag blocks a following request. A behavioural model, run on every clock, predicts strobe, completion and flag timing in both sampling modes.

// File: rtl/busm_pkg.sv
package busm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_T1    = 2'd1,
    ST_T2    = 2'd2,
    ST_RWAIT = 2'd3
  } busm_state_e;

  localparam int SENSE_W = 4;

  typedef struct packed {
    logic ack0_n;
    logic ack1_n;
    logic rdy;
    logic retry_n;
  } busm_sense_t;
endpackage

// File: rtl/busm_sense_sync.sv
module busm_sense_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         async_en,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sensed
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign sensed = async_en ? pipe[STAGES-1] : raw;
endmodule

// File: rtl/busm_term_decode.sv
module busm_term_decode
  import busm_pkg::*;
(
  input  logic        rdy_mode,
  input  logic        wide,
  input  busm_sense_t sense,
  output logic        term,
  output logic        retry
);
  logic ack_end;

  always_comb begin
    if (wide) ack_end = !sense.ack0_n && !sense.ack1_n;
    else      ack_end = !sense.ack1_n;
    term  = rdy_mode ? !sense.rdy : ack_end;
    retry = !sense.retry_n;
  end
endmodule

// File: rtl/busm_ecs_gen.sv
module busm_ecs_gen (
  input  logic clk,
  input  logic rst,
  input  logic in_t1,
  output logic ecs_n
);
  logic half_seen;

  always_ff @(negedge clk) begin
    if (rst) half_seen <= 1'b0;
    else     half_seen <= in_t1;
  end

  assign ecs_n = !(in_t1 && !half_seen);
endmodule

// File: rtl/busm_cycle_ctrl.sv
module busm_cycle_ctrl
  import busm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rdy_mode,
  input  logic          cfg_wide,
  input  logic          cfg_async,
  input  logic          cfg_retry_latch,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_write,
  output logic          ecs_n,
  output logic          ds_n,
  input  logic [DW-1:0] bus_rdata,
  input  logic          ack0_n,
  input  logic          ack1_n,
  input  logic          rdy_in,
  input  logic          retry_n,
  output logic          retry_flag,
  input  logic          retry_clr
);
  localparam logic [SENSE_W-1:0] SENSE_IDLE = '1;

  busm_state_e state;
  busm_sense_t raw_sense, sense;
  logic        term, retry_hit, in_t1, flag_set;

  assign raw_sense = '{ack0_n: ack0_n, ack1_n: ack1_n, rdy: rdy_in, retry_n: retry_n};

  busm_sense_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL(SENSE_IDLE)) u_sync (
    .clk(clk), .rst(rst), .async_en(cfg_async),
    .raw(raw_sense), .sensed(sense)
  );

  busm_term_decode u_dec (
    .rdy_mode(cfg_rdy_mode), .wide(cfg_wide), .sense(sense),
    .term(term), .retry(retry_hit)
  );

  assign in_t1 = (state == ST_T1);

  busm_ecs_gen u_ecs (.clk(clk), .rst(rst), .in_t1(in_t1), .ecs_n(ecs_n));

  assign flag_set = (state == ST_T2) && retry_hit && cfg_retry_latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      ds_n      <= 1'b1;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_write <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && !retry_flag) begin
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
            bus_write <= req_write;
            busy      <= 1'b1;
            state     <= ST_T1;
          end
        end
        ST_T1: begin
          ds_n  <= 1'b0;
          state <= ST_T2;
        end
        ST_T2: begin
          if (retry_hit) begin
            ds_n  <= 1'b1;
            state <= ST_RWAIT;
          end else if (term) begin
            ds_n  <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
            if (!bus_write) rd_data <= bus_rdata;
          end
        end
        ST_RWAIT: begin
          if (!retry_hit) state <= ST_T1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            retry_flag <= 1'b0;
    else if (flag_set)  retry_flag <= 1'b1;
    else if (retry_clr) retry_flag <= 1'b0;
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_strobe_off_t1_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1) |-> ds_n);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr));
  p_retry_nodone_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RWAIT) |-> !done);
  p_flag_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && retry_flag) |=> (state == ST_IDLE));
  p_flag_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_retry_latch && !retry_flag) |=> !retry_flag);
endmodule

// File: tb/sim_busm_cycle_ctrl.sv
module sim_busm_cycle_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rdy_mode = 0, cfg_wide = 1, cfg_async = 0, cfg_retry_latch = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic ack0_n = 1, ack1_n = 1, rdy_in = 1, retry_n = 1, retry_clr = 0;
  logic busy, done, bus_write, ecs_n, ds_n, retry_flag;
  logic [DW-1:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_addr;

  int n_run = 0, n_fail = 0, cyc = 0, done_cnt = 0;

  always #4 clk = ~clk;

  busm_cycle_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_rdy_mode(cfg_rdy_mode), .cfg_wide(cfg_wide),
    .cfg_async(cfg_async), .cfg_retry_latch(cfg_retry_latch),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
    .ecs_n(ecs_n), .ds_n(ds_n), .bus_rdata(bus_rdata), .ack0_n(ack0_n),
    .ack1_n(ack1_n), .rdy_in(rdy_in), .retry_n(retry_n),
    .retry_flag(retry_flag), .retry_clr(retry_clr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 first clock, 2 strobe, 3 retry hold
  int m_phase = 0;
  bit m_busy, m_done, m_ds = 1, m_flag, m_wr;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rd;
  bit [3:0] hist1 = 4'hF, hist2 = 4'hF;

  always @(posedge clk) begin
    bit [3:0] now, eff;
    bit term, rty, setf;
    now = {ack0_n, ack1_n, rdy_in, retry_n};
    if (rst) begin
      m_phase = 0; m_busy = 0; m_done = 0; m_ds = 1; m_flag = 0; m_wr = 0;
      m_addr = '0; m_wd = '0; m_rd = '0; hist1 = 4'hF; hist2 = 4'hF;
    end else begin
      eff = cfg_async ? hist2 : now;
      hist2 = hist1; hist1 = now;
      if (cfg_rdy_mode) term = (eff[1] == 0);
      else if (cfg_wide) term = (eff[3] == 0) && (eff[2] == 0);
      else term = (eff[2] == 0);
      rty = (eff[0] == 0);
      m_done = 0; setf = 0;
      if (m_phase == 0) begin
        if (req_valid && !m_flag) begin
          m_addr = req_addr; m_wd = req_wdata; m_wr = req_write;
          m_busy = 1; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        m_ds = 0; m_phase = 2;
      end else if (m_phase == 2) begin
        if (rty) begin
          m_ds = 1; m_phase = 3; setf = cfg_retry_latch;
        end else if (term) begin
          m_ds = 1; m_done = 1; m_busy = 0; m_phase = 0;
          if (!m_wr) m_rd = bus_rdata;
        end
      end else begin
        if (!rty) m_phase = 1;
      end
      if (setf) m_flag = 1;
      else if (retry_clr) m_flag = 0;
    end
  end

  always @(posedge clk) begin
    #2;
    cyc++;
    if (done === 1'b1) done_cnt++;
    if (!rst) begin
      chk(busy === m_busy, "R6", "busy", busy, m_busy);
      chk(done === m_done, "R6", "done", done, m_done);
      chk(ds_n === m_ds, "R2", "ds_n", ds_n, m_ds);
      chk(ecs_n === !(m_phase == 1), "R1", "ecs_n rising half", ecs_n, !(m_phase == 1));
      chk(bus_addr === m_addr, "R7", "bus_addr", bus_addr, m_addr);
      chk(bus_write === m_wr, "R7", "bus_write", bus_write, m_wr);
      chk(bus_wdata === m_wd, "R7", "bus_wdata", bus_wdata, m_wd);
      chk(retry_flag === m_flag, "R9", "retry_flag", retry_flag, m_flag);
      chk(rd_data === m_rd, "R6", "rd_data", rd_data, m_rd);
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst) chk(ecs_n === 1'b1, "R1", "ecs_n falling half", ecs_n, 1);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_lines();
    ack0_n = 1; ack1_n = 1; rdy_in = 1; retry_n = 1;
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    tick(1);
    req_valid = 0;
  endtask

  task automatic settle();
    idle_lines();
    tick(6);
  endtask

  int base, lat;

  initial begin
    tick(3);
    chk(busy === 0 && done === 0, "R6", "reset busy/done", {busy, done}, 0);
    chk(ds_n === 1 && ecs_n === 1, "R2", "reset strobes", {ds_n, ecs_n}, 2'b11);
    chk(retry_flag === 0, "R9", "reset flag", retry_flag, 0);
    rst = 0;
    tick(2);

    // R3: wide acknowledge, read
    cfg_rdy_mode = 0; cfg_wide = 1; bus_rdata = 32'hCAFE_0001;
    base = done_cnt;
    issue(0, 32'h0000_1000, '0);
    ack0_n = 0; tick(6);
    chk(done_cnt == base, "R3", "ack0 alone waits", done_cnt - base, 0);
    ack1_n = 0; tick(3);
    chk(done_cnt == base + 1, "R3", "both acks end", done_cnt - base, 1);
    chk(rd_data === 32'hCAFE_0001, "R6", "read capture", rd_data, 32'hCAFE_0001);
    settle();

    // R4: narrow acknowledge, write
    cfg_wide = 0; base = done_cnt;
    issue(1, 32'h0000_2004, 32'h1234_5678);
    ack0_n = 0; tick(6);
    chk(done_cnt == base, "R4", "ack0 ignored narrow", done_cnt - base, 0);
    ack0_n = 1; ack1_n = 0; tick(3);
    chk(done_cnt == base + 1, "R4", "ack1 ends narrow", done_cnt - base, 1);
    settle();

    // R5: ready mode
    cfg_rdy_mode = 1; cfg_wide = 1; base = done_cnt;
    issue(0, 32'h0000_3008, '0);
    ack0_n = 0; ack1_n = 0; tick(6);
    chk(done_cnt == base, "R5", "ready high waits, acks ignored", done_cnt - base, 0);
    rdy_in = 0; tick(3);
    chk(done_cnt == base + 1, "R5", "ready low ends", done_cnt - base, 1);
    settle();

    // R11: synchronous latency
    cfg_rdy_mode = 0; cfg_async = 0;
    issue(0, 32'h0000_4000, '0); tick(4);
    ack0_n = 0; ack1_n = 0; lat = 0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk); #2;
      if (done === 1'b1 && lat == 0) lat = i;
    end
    chk(lat == 1, "R11", "direct sampling latency", lat, 1);
    settle();

    // R10: synchronized latency
    cfg_async = 1;
    issue(0, 32'h0000_4010, '0); tick(4);
    ack0_n = 0; ack1_n = 0; lat = 0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk); #2;
      if (done === 1'b1 && lat == 0) lat = i;
    end
    chk(lat == 3, "R10", "synchronizer latency", lat, 3);
    settle();
    cfg_async = 0;

    // R8 + R7: retry collides with termination, non-latched
    cfg_retry_latch = 0; base = done_cnt;
    issue(1, 32'h0000_5550, 32'hA5A5_0F0F); tick(2);
    retry_n = 0; ack0_n = 0; ack1_n = 0; tick(5);
    chk(done_cnt == base, "R8", "retry beats termination", done_cnt - base, 0);
    chk(busy === 1, "R7", "still busy during retry", busy, 1);
    chk(bus_addr === 32'h0000_5550, "R7", "address kept", bus_addr, 32'h0000_5550);
    retry_n = 1; tick(5);
    chk(done_cnt == base + 1, "R7", "replay completes", done_cnt - base, 1);
    chk(retry_flag === 0, "R9", "flag stays clear unlatched", retry_flag, 0);
    settle();

    // R9: latched retry
    cfg_retry_latch = 1; base = done_cnt;
    issue(0, 32'h0000_6660, '0); tick(2);
    retry_n = 0; ack0_n = 0; ack1_n = 0; tick(3);
    retry_n = 1; tick(5);
    chk(done_cnt == base + 1, "R9", "replay completes latched", done_cnt - base, 1);
    chk(retry_flag === 1, "R9", "flag set", retry_flag, 1);
    idle_lines(); tick(2);
    issue(0, 32'h0000_7770, '0); tick(4);
    chk(busy === 0, "R9", "request blocked by flag", busy, 0);
    retry_clr = 1; tick(1); retry_clr = 0;
    chk(retry_flag === 0, "R9", "flag cleared", retry_flag, 0);
    base = done_cnt;
    issue(0, 32'h0000_7780, '0);
    ack0_n = 0; ack1_n = 0; tick(4);
    chk(done_cnt == base + 1, "R9", "request after clear", done_cnt - base, 1);
    chk(bus_addr === 32'h0000_7780, "R9", "new address", bus_addr, 32'h0000_7780);
    settle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule